// File: doc/BRIEF.md
# Frame-Synchronized TDM Serial Transmitter

This block sends multichannel sample words over a single serial line. A bit clock (DCLK) is divided down from the core clock by an integer setting. A one-period frame marker (FSYNC) separates conversion periods. In each frame the block captures a set of parallel channel samples. It then shifts the selected number of channels out on DOUT, one word after another, each word most significant bit first.

The receiver samples DOUT and FSYNC on the rising edge of DCLK. The block changes both only on the falling edge. The frame length is set in DCLK periods, and the block compares it with the bits the frame must carry. When the words do not fit, the bits left over are discarded, the next frame starts on time with fresh samples, and a sticky overrun flag is raised. The divider, the channel count, the word size and the frame length are taken into use only at a frame boundary.

Top module: `tdm_fsync_port`

## Requirements
- R1: With divider setting D (0 treated as 1), DCLK is high for D core clock cycles and low for D core clock cycles. Settings 1 and 2 are both supported.
- R2: DOUT and FSYNC change only in the core cycle in which DCLK falls, so both are stable at every DCLK rising edge.
- R3: FSYNC is high for exactly one DCLK period, the last period of each frame, and low in every other period of the frame.
- R4: A frame lasts exactly `cfg_len_i` DCLK periods (2 or more). The word bits fill periods 0, 1, 2, and so on of the frame.
- R5: Channel-count code `cfg_tdm_i` selects 1, 2, 4 or 8 channels (codes 0, 1, 2, 3). Channels are sent in ascending order, and channel c is taken from `samples_i[c*40 +: 40]`.
- R6: `cfg_wide_i`=0 selects 24-bit words, taken from bits [23:0] of each channel slot. `cfg_wide_i`=1 selects 40-bit words. Each word is sent most significant bit first.
- R7: The most significant bit of channel 0 is driven at the DCLK fall that ends the FSYNC period. It is therefore valid at the next DCLK rising edge.
- R8: Samples are captured at the frame start. Changes to `samples_i` during a frame do not alter the bits of that frame.
- R9: After the last word bit of a frame, DOUT stays low until the frame ends.
- R10: The divider, channel count, word size and frame length are latched at the frame start. Changes during a frame take effect only from the next frame.
- R11: If channels × word bits exceeds the frame length, only the first `cfg_len_i` bits are sent and the rest are dropped. The next frame starts with newly captured samples. `overrun_o` goes high at that frame start and stays high until reset.
- R12: After reset, `dclk_o`, `fsync_o`, `dout_o` and `overrun_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div_i | input | DIV_W | DCLK half-period in core cycles |
| cfg_tdm_i | input | 2 | Channel-count code: 1, 2, 4 or 8 channels |
| cfg_wide_i | input | 1 | Word size: 0 selects 24 bits, 1 selects 40 bits |
| cfg_len_i | input | LEN_W | Frame length in DCLK periods |
| samples_i | input | 320 | Eight 40-bit channel slots; channel c is in bits [c*40 +: 40] |
| dclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame marker, high during the last period of each frame |
| dout_o | output | 1 | Serial data |
| overrun_o | output | 1 | Sticky flag for lost bits |

## Verification
The assertion that FSYNC lasts one period assumes that `cfg_len_i` is at least 2 whenever a frame starts. Every configuration the stimulus applies uses a frame length of 30 or more. The edge-alignment and sticky-flag properties depend only on reset having been applied once, and the stimulus holds reset for several core cycles before the first DCLK edge. Configuration and sample changes are made either at frame boundaries or deliberately in the middle of a frame, and never while reset is active.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
  localparam int SLOT_W   = 40;
  localparam int NARROW_W = 24;
  localparam int WIDE_W   = 40;
  localparam int MAX_CH   = 8;
  localparam int STREAM_W = MAX_CH * SLOT_W;
  localparam int CNT_W    = $clog2(STREAM_W + 1);

  // bits carried by one frame for a channel code and a word size
  function automatic logic [CNT_W-1:0] frame_bits(input logic [1:0] code, input logic wide);
    int ch;
    int w;
    ch = 1 << code;
    w  = wide ? WIDE_W : NARROW_W;
    return CNT_W'(ch * w);
  endfunction
endpackage

// File: rtl/tdm_bitclk_gen.sv
module tdm_bitclk_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             dclk_o,
  output logic             fall_en_o
);
  logic [DIV_W-1:0] hcnt;
  logic [DIV_W-1:0] last;
  logic             toggle;

  assign last      = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign toggle    = (hcnt >= last);
  assign fall_en_o = toggle & dclk_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt   <= '0;
      dclk_o <= 1'b0;
    end else if (toggle) begin
      hcnt   <= '0;
      dclk_o <= ~dclk_o;
    end else begin
      hcnt   <= hcnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl #(
  parameter int DIV_W = 4,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_en_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             pending_i,
  output logic             start_o,
  output logic [DIV_W-1:0] div_o,
  output logic             fsync_o,
  output logic             overrun_o
);
  logic             run;
  logic [LEN_W-1:0] fcnt;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W:0]   cnt_ahead;

  assign start_o   = fall_en_i & fsync_o;
  assign cnt_ahead = {1'b0, fcnt} + (LEN_W+1)'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      fcnt      <= '0;
      len_q     <= '0;
      div_o     <= cfg_div_i;
      fsync_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else if (fall_en_i) begin
      if (!run) begin
        run     <= 1'b1;
        fsync_o <= 1'b1;
      end else if (fsync_o) begin
        fcnt    <= '0;
        len_q   <= cfg_len_i;
        div_o   <= cfg_div_i;
        fsync_o <= (cfg_len_i <= LEN_W'(1));
        if (pending_i) overrun_o <= 1'b1;
      end else begin
        fcnt    <= fcnt + LEN_W'(1);
        fsync_o <= (cnt_ahead >= {1'b0, len_q});
      end
    end
  end
endmodule

// File: rtl/tdm_word_shifter.sv
module tdm_word_shifter
  import tdm_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic [1:0]          cfg_tdm_i,
  input  logic                cfg_wide_i,
  input  logic [STREAM_W-1:0] samples_i,
  output logic                dout_o,
  output logic                pending_o
);
  logic [STREAM_W-1:0] stream;
  logic [STREAM_W-1:0] shreg;
  logic [CNT_W-1:0]    left;

  // pack the selected word size contiguously, channel 0 at the top
  always_comb begin
    stream = '0;
    if (cfg_wide_i) begin
      for (int c = 0; c < MAX_CH; c++)
        stream[STREAM_W - (c+1)*WIDE_W +: WIDE_W] = samples_i[c*SLOT_W +: WIDE_W];
    end else begin
      for (int c = 0; c < MAX_CH; c++)
        stream[STREAM_W - (c+1)*NARROW_W +: NARROW_W] = samples_i[c*SLOT_W +: NARROW_W];
    end
  end

  assign pending_o = (left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      left   <= '0;
      dout_o <= 1'b0;
    end else if (load_i) begin
      dout_o <= stream[STREAM_W-1];
      shreg  <= stream << 1;
      left   <= frame_bits(cfg_tdm_i, cfg_wide_i) - CNT_W'(1);
    end else if (shift_i) begin
      if (left != '0) begin
        dout_o <= shreg[STREAM_W-1];
        shreg  <= shreg << 1;
        left   <= left - CNT_W'(1);
      end else begin
        dout_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_fsync_port.sv
module tdm_fsync_port
  import tdm_port_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int LEN_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    cfg_div_i,
  input  logic [1:0]          cfg_tdm_i,
  input  logic                cfg_wide_i,
  input  logic [LEN_W-1:0]    cfg_len_i,
  input  logic [STREAM_W-1:0] samples_i,
  output logic                dclk_o,
  output logic                fsync_o,
  output logic                dout_o,
  output logic                overrun_o
);
  logic             fall_en;
  logic             start;
  logic             pending;
  logic [DIV_W-1:0] div_q;

  tdm_bitclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk       (clk),
    .rst       (rst),
    .div_i     (div_q),
    .dclk_o    (dclk_o),
    .fall_en_o (fall_en)
  );

  tdm_frame_ctrl #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .fall_en_i (fall_en),
    .cfg_div_i (cfg_div_i),
    .cfg_len_i (cfg_len_i),
    .pending_i (pending),
    .start_o   (start),
    .div_o     (div_q),
    .fsync_o   (fsync_o),
    .overrun_o (overrun_o)
  );

  tdm_word_shifter u_shift (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start),
    .shift_i    (fall_en),
    .cfg_tdm_i  (cfg_tdm_i),
    .cfg_wide_i (cfg_wide_i),
    .samples_i  (samples_i),
    .dout_o     (dout_o),
    .pending_o  (pending)
  );
endmodule

// File: rtl/tdm_fsync_port_chk.sv
module tdm_fsync_port_chk (
  input logic clk,
  input logic rst,
  input logic dclk,
  input logic fsync,
  input logic dout,
  input logic overrun
);
  // R2: serial data moves only when the bit clock falls
  assert_dout_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> (!dclk && $past(dclk)));

  // R2: frame marker moves only when the bit clock falls
  assert_fsync_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (fsync != $past(fsync)) |-> (!dclk && $past(dclk)));

  // R3: marker lasts a single bit period
  assert_fsync_single_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(dclk) && $past(fsync)) |-> !fsync);

  // R11: overrun flag holds once set
  assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    $past(overrun) |-> overrun);

  // R11: overrun is raised at a frame start, on a falling bit clock
  assert_overrun_on_fall_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $fell(dclk));
endmodule

bind tdm_fsync_port tdm_fsync_port_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .dclk    (dclk_o),
  .fsync   (fsync_o),
  .dout    (dout_o),
  .overrun (overrun_o)
);

// File: tb/tdm_fsync_port_tb_top.sv
module tdm_fsync_port_tb_top;
  import tdm_port_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 4;
  localparam int LEN_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIV_W-1:0]    cfg_div;
  logic [1:0]          cfg_tdm;
  logic                cfg_wide;
  logic [LEN_W-1:0]    cfg_len;
  logic [STREAM_W-1:0] samples;
  logic dclk_o, fsync_o, dout_o, overrun_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // values applied in the middle of a frame by check_frame
  logic [DIV_W-1:0]    nx_div;
  logic [1:0]          nx_tdm;
  logic                nx_wide;
  logic [LEN_W-1:0]    nx_len;
  logic [STREAM_W-1:0] nx_smp;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_fsync_port #(.DIV_W(DIV_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_div_i(cfg_div), .cfg_tdm_i(cfg_tdm),
    .cfg_wide_i(cfg_wide), .cfg_len_i(cfg_len), .samples_i(samples),
    .dclk_o(dclk_o), .fsync_o(fsync_o), .dout_o(dout_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [STREAM_W-1:0] mk_samples(input int seed);
    logic [STREAM_W-1:0] s;
    for (int c = 0; c < MAX_CH; c++)
      s[c*SLOT_W +: SLOT_W] = {8'(seed*16 + c + 1), 32'(seed*32'h01000193) ^ 32'(c*32'h9E3779B9)};
    return s;
  endfunction

  // expected serial stream from the requirements: ascending channels, MSB first
  function automatic logic [STREAM_W-1:0] expect_stream(input logic [STREAM_W-1:0] s,
                                                      input int nch, input int w);
    logic [STREAM_W-1:0] e = '0;
    int k = 0;
    for (int c = 0; c < nch; c++)
      for (int b = w-1; b >= 0; b--) begin
        e[STREAM_W-1-k] = s[c*SLOT_W + b];
        k++;
      end
    return e;
  endfunction

  task automatic apply(input int d, input int t, input bit w, input int l, input logic [STREAM_W-1:0] s);
    cfg_div = DIV_W'(d); cfg_tdm = 2'(t); cfg_wide = w; cfg_len = LEN_W'(l); samples = s;
  endtask

  task automatic wait_sync();
    do @(posedge dclk_o); while (fsync_o !== 1'b1);
  endtask

  // checks one frame at the receiver's sampling edges; returns at the FSYNC period
  task automatic check_frame(input logic [STREAM_W-1:0] exp, input int nbits, input int len,
                             input int mid, input bit exp_ovr, input string req);
    for (int i = 0; i < len; i++) begin
      @(posedge dclk_o);
      if (i == mid) apply(nx_div, nx_tdm, nx_wide, nx_len, nx_smp);
      if (i == 0) chk(overrun_o == exp_ovr, "R11", "overrun at frame start", overrun_o, exp_ovr);
      if (i < nbits)
        chk(dout_o == exp[STREAM_W-1-i], req, $sformatf("data bit %0d", i), dout_o, exp[STREAM_W-1-i]);
      else
        chk(dout_o == 1'b0, "R9", $sformatf("idle bit %0d", i), dout_o, 0);
      chk(fsync_o == (i == len-1), "R3", $sformatf("fsync in period %0d", i), fsync_o, (i == len-1));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(dclk_o == 0, "R12", "dclk after reset", dclk_o, 0);
    chk(fsync_o == 0, "R12", "fsync after reset", fsync_o, 0);
    chk(dout_o == 0, "R12", "dout after reset", dout_o, 0);
    chk(overrun_o == 0, "R12", "overrun after reset", overrun_o, 0);
    wait_sync();
  endtask

  task automatic t_div(input int d);
    time t0, t1, t2;
    apply(d, 1, 1'b0, 60, mk_samples(2));
    @(posedge dclk_o); t0 = $time;
    @(negedge dclk_o); t1 = $time;
    @(posedge dclk_o); t2 = $time;
    chk((t1 - t0) == d*CLK_PERIOD, "R1", "dclk high time", t1 - t0, d*CLK_PERIOD);
    chk((t2 - t0) == 2*d*CLK_PERIOD, "R1", "dclk period", t2 - t0, 2*d*CLK_PERIOD);
    wait_sync();
  endtask

  task automatic t_frame(input int d, input int t, input bit w, input int l, input int seed, input string req);
    logic [STREAM_W-1:0] s = mk_samples(seed);
    int nch = 1 << t;
    int wb  = w ? WIDE_W : NARROW_W;
    apply(d, t, w, l, s);
    check_frame(expect_stream(s, nch, wb), nch*wb, l, -1, 1'b0, req);
  endtask

  task automatic t_midframe();
    logic [STREAM_W-1:0] sa = mk_samples(11);
    logic [STREAM_W-1:0] sb = mk_samples(12);
    apply(1, 1, 1'b1, 100, sa);
    nx_div = 2; nx_tdm = 2; nx_wide = 1'b0; nx_len = 110; nx_smp = sb;
    // R8 and R10: frame in progress keeps old samples, length and word format
    check_frame(expect_stream(sa, 2, WIDE_W), 80, 100, 5, 1'b0, "R8");
    // R10: new settings take effect at the following frame
    check_frame(expect_stream(sb, 4, NARROW_W), 96, 110, -1, 1'b0, "R10");
  endtask

  task automatic t_overrun();
    logic [STREAM_W-1:0] sc = mk_samples(21);
    logic [STREAM_W-1:0] sd = mk_samples(22);
    apply(1, 1, 1'b0, 40, sc);
    check_frame(expect_stream(sc, 2, NARROW_W), 48, 40, -1, 1'b0, "R11");
    chk(overrun_o == 0, "R11", "overrun before short frame ends", overrun_o, 0);
    apply(1, 0, 1'b1, 50, sd);
    check_frame(expect_stream(sd, 1, WIDE_W), 40, 50, -1, 1'b1, "R11");
    check_frame(expect_stream(sd, 1, WIDE_W), 40, 50, -1, 1'b1, "R11");
  endtask

  initial begin
    apply(1, 1, 1'b0, 60, mk_samples(1));
    nx_div = 1; nx_tdm = 0; nx_wide = 0; nx_len = 30; nx_smp = '0;
    t_reset();
    t_div(1);
    t_div(2);
    t_frame(1, 0, 1'b0, 30, 3, "R6");
    t_frame(2, 1, 1'b1, 90, 5, "R7");
    t_frame(1, 2, 1'b0, 96, 7, "R4");
    t_frame(1, 3, 1'b1, 325, 9, "R5");
    t_midframe();
    t_overrun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule